// File: doc/BRIEF.md
# Storage Test Pattern Generator

This block chooses the word that goes into the storage data register while storage is being exercised. A 3-bit test selector picks either normal operation or one of four fixed test patterns. In normal operation the incoming data word passes through unchanged. Under a pattern code the block replaces that word with a generated one and raises a force-enable flag.

Two of the patterns are fixed: a word of zeros and a word of ones. The other two alternate between zeros and ones. For these, the choice depends on the exclusive-OR of two address bits. When the address steps by one word (+4) at a time, the result is two zero words followed by two one words, or the reverse.

The block is purely combinational. The generated word, the force flag and the muxed word all follow the selector and the address with no clock delay.

Top module: `stpg_top`

## Requirements
- R1: With selector code 0 (process), `force_en` is 0 and `sdr_word` equals `norm_data`.
- R2: Selector codes 5, 6 and 7 behave exactly like code 0: `force_en` is 0 and `sdr_word` equals `norm_data`.
- R3: With code 1, `pat_word` is all zeros, `force_en` is 1 and `sdr_word` is all zeros, whatever the address and `norm_data`.
- R4: With code 2, `pat_word` is all ones, `force_en` is 1 and `sdr_word` is all ones, whatever the address and `norm_data`.
- R5: Address bits are numbered big-endian: bit 0 is the MSB and bit 31 is the LSB, so bit 17 is `addr[14]` and bit 28 is `addr[3]`. With code 3 (worst), every bit of `pat_word` equals `addr[14] ^ addr[3]`, and `sdr_word` equals `pat_word`.
- R6: With code 4 (reverse worst), `pat_word` is the bitwise complement of the code-3 word for the same address.
- R7: With code 3 and the address stepping from 0 in steps of 4, the words are zeros, zeros, ones, ones, and this repeats.
- R8: `force_en` is 1 exactly for codes 1 to 4. Whenever `force_en` is 1, `sdr_word` equals `pat_word`.
- R9: The outputs settle within the same cycle that `sel`, `addr` or `norm_data` change. No clock is involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sel | input | 3 | Test selector: 0 = process, 1 = zeros, 2 = ones, 3 = worst, 4 = reverse worst, 5 to 7 = process |
| addr | input | 32 | Current address register value; bit 31 of the big-endian numbering is `addr[0]` |
| norm_data | input | DATA_W | Data word used when no pattern is selected |
| pat_word | output | DATA_W | Generated test pattern word |
| force_en | output | 1 | High when the pattern replaces the normal data |
| sdr_word | output | DATA_W | Word presented to the storage data register |

## Verification
A wrong decode shows up at once as a `force_en` value that disagrees with the selector code, or as normal data leaking through under a pattern code. A wrong toggle-bit position appears only at certain address steps, so the bench walks word addresses across both toggling bits. It also checks the MSB and the LSB of every word, to catch a broken replication. Because the block has no state, each fault is visible in the same cycle as the stimulus that exposes it.

// File: rtl/stpg_pkg.sv
package stpg_pkg;

    typedef enum logic [2:0] {
        TST_PROCESS = 3'd0,
        TST_ZEROS   = 3'd1,
        TST_ONES    = 3'd2,
        TST_WORST   = 3'd3,
        TST_RWORST  = 3'd4
    } tst_code_e;

    // force_en : pattern replaces normal data
    // alt      : level is flipped by the address phase
    // level    : base fill value
    typedef struct packed {
        logic force_en;
        logic alt;
        logic level;
    } tst_decode_t;

endpackage

// File: rtl/stpg_decode.sv
module stpg_decode
    import stpg_pkg::*;
(
    input  logic [2:0]  sel,
    output tst_decode_t dec
);
    tst_decode_t dec_d;

    always_comb begin
        dec_d = '0;
        case (sel)
            TST_ZEROS:  dec_d = '{force_en: 1'b1, alt: 1'b0, level: 1'b0};
            TST_ONES:   dec_d = '{force_en: 1'b1, alt: 1'b0, level: 1'b1};
            TST_WORST:  dec_d = '{force_en: 1'b1, alt: 1'b1, level: 1'b0};
            TST_RWORST: dec_d = '{force_en: 1'b1, alt: 1'b1, level: 1'b1};
            default:    dec_d = '0;
        endcase
    end

    assign dec = dec_d;

    // R2: unused codes never force
    always_comb begin
        if (!$isunknown(sel) && sel > 3'd4)
            a_r2_spare_codes_idle: assert (dec_d.force_en == 1'b0);
    end
endmodule

// File: rtl/stpg_phase.sv
module stpg_phase #(
    parameter int ADDR_W = 32,
    parameter int BIT_A  = 17,
    parameter int BIT_B  = 28
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              phase
);
    // big-endian bit numbers converted to vector indices
    localparam int IDX_A = ADDR_W - 1 - BIT_A;
    localparam int IDX_B = ADDR_W - 1 - BIT_B;
    localparam logic [ADDR_W-1:0] TOGGLE_MASK =
        (ADDR_W'(1) << IDX_A) | (ADDR_W'(1) << IDX_B);

    logic phase_d;

    always_comb begin
        phase_d = ^(addr & TOGGLE_MASK);
    end

    assign phase = phase_d;

    // R5: phase follows the two selected bits
    always_comb begin
        if (!$isunknown(addr))
            a_r5_phase_bits: assert (phase_d == (addr[IDX_A] != addr[IDX_B]));
    end
endmodule

// File: rtl/stpg_fill.sv
module stpg_fill
    import stpg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  tst_decode_t       dec,
    input  logic              phase,
    input  logic [DATA_W-1:0] norm_data,
    output logic [DATA_W-1:0] pat_word,
    output logic [DATA_W-1:0] sdr_word
);
    logic fill_bit_d;

    always_comb begin
        fill_bit_d = dec.level ^ (dec.alt & phase);
    end

    for (genvar g = 0; g < DATA_W; g++) begin : g_rep
        assign pat_word[g] = fill_bit_d;
    end

    assign sdr_word = dec.force_en ? pat_word : norm_data;
endmodule

// File: rtl/stpg_top.sv
module stpg_top
    import stpg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int BIT_A  = 17,
    parameter int BIT_B  = 28
) (
    input  logic [2:0]        sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] norm_data,
    output logic [DATA_W-1:0] pat_word,
    output logic              force_en,
    output logic [DATA_W-1:0] sdr_word
);
    tst_decode_t dec;
    logic        phase;

    stpg_decode u_decode (
        .sel (sel),
        .dec (dec)
    );

    stpg_phase #(
        .ADDR_W (ADDR_W),
        .BIT_A  (BIT_A),
        .BIT_B  (BIT_B)
    ) u_phase (
        .addr  (addr),
        .phase (phase)
    );

    stpg_fill #(
        .DATA_W (DATA_W)
    ) u_fill (
        .dec       (dec),
        .phase     (phase),
        .norm_data (norm_data),
        .pat_word  (pat_word),
        .sdr_word  (sdr_word)
    );

    assign force_en = dec.force_en;

    always_comb begin
        if (!$isunknown({sel, addr, norm_data})) begin
            // R8: force exactly for codes 1..4
            a_r8_force_codes: assert (force_en == (sel >= 3'd1 && sel <= 3'd4));
            // R3 / R4: fixed words reach the register
            if (sel == TST_ZEROS)
                a_r3_zero_word: assert (sdr_word == '0);
            if (sel == TST_ONES)
                a_r4_ones_word: assert (sdr_word == '1);
            // R1: process passes data through
            if (sel == TST_PROCESS)
                a_r1_pass_through: assert (sdr_word == norm_data && !force_en);
            // R6: the alternating modes are complementary for the same phase
            if (sel == TST_RWORST)
                a_r6_rworst_level: assert (pat_word == {DATA_W{~phase}});
        end
    end
endmodule

// File: tb/stpg_top_test.sv
module stpg_top_test;
    logic        clk = 1'b0;
    logic [2:0]  sel;
    logic [31:0] addr;
    logic [31:0] norm_data;
    logic [31:0] pat_word;
    logic        force_en;
    logic [31:0] sdr_word;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    stpg_top uut (
        .sel       (sel),
        .addr      (addr),
        .norm_data (norm_data),
        .pat_word  (pat_word),
        .force_en  (force_en),
        .sdr_word  (sdr_word)
    );

    task automatic apply(input logic [2:0] s, input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = s; addr = a; norm_data = d;
        #2;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic ph(input logic [31:0] a);
        return a[31-17] ^ a[31-28];
    endfunction

    task automatic t_process();
        apply(3'd0, 32'h0000_4008, 32'hDEAD_BEEF);
        check("R1 force", {31'd0, force_en}, 32'd0);
        check("R1 data", sdr_word, 32'hDEAD_BEEF);
        apply(3'd0, 32'h0000_0000, 32'h1234_5678);
        check("R9 data follows", sdr_word, 32'h1234_5678);
    endtask

    task automatic t_spare();
        for (int c = 5; c < 8; c++) begin
            apply(3'(c), 32'h0000_0008, 32'hA5A5_0F0F);
            check("R2 force", {31'd0, force_en}, 32'd0);
            check("R2 data", sdr_word, 32'hA5A5_0F0F);
        end
    endtask

    task automatic t_fixed();
        apply(3'd1, 32'h0000_0008, 32'hFFFF_FFFF);
        check("R3 pat", pat_word, 32'h0);
        check("R3 sdr", sdr_word, 32'h0);
        check("R3 force", {31'd0, force_en}, 32'd1);
        apply(3'd2, 32'h0000_4000, 32'h0);
        check("R4 pat", pat_word, 32'hFFFF_FFFF);
        check("R4 sdr", sdr_word, 32'hFFFF_FFFF);
        check("R8 force", {31'd0, force_en}, 32'd1);
    endtask

    task automatic t_worst_bits();
        logic [31:0] al [4] = '{32'h0, 32'h8, 32'h4000, 32'h4008};
        foreach (al[i]) begin
            apply(3'd3, al[i], 32'h5555_AAAA);
            check("R5 worst", pat_word, {32{ph(al[i])}});
            check("R8 sdr=pat", sdr_word, {32{ph(al[i])}});
            apply(3'd4, al[i], 32'h5555_AAAA);
            check("R6 rworst", pat_word, {32{~ph(al[i])}});
            check("R6 force", {31'd0, force_en}, 32'd1);
        end
    endtask

    task automatic t_walk();
        logic [31:0] seq [8] = '{32'h0, 32'h0, '1, '1, 32'h0, 32'h0, '1, '1};
        for (int k = 0; k < 8; k++) begin
            apply(3'd3, 32'(k * 4), 32'h0);
            check("R7 walk", sdr_word, seq[k]);
        end
        for (int k = 0; k < 4; k++) begin
            apply(3'd4, 32'(k * 4), 32'h0);
            check("R7 reverse walk", sdr_word, ~seq[k]);
        end
    endtask

    initial begin
        sel = 3'd0; addr = '0; norm_data = '0;
        #2;
        check("R1 initial", {31'd0, force_en}, 32'd0);
        t_process();
        t_spare();
        t_fixed();
        t_worst_bits();
        t_walk();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_fail++;
        n_run++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule